// File: doc/BRIEF.md
# Multicart Pattern-Bus Bank Mapper

This block turns a pattern-bus (CHR) request from a scanline-counter style bank mapper into a physical address on a multi-game cartridge. It combines four inputs: the inner mapper's 1 KB bank request for the current address, that mapper's command register, a group of outer extension registers, and a 2-bit latched value. From them it picks one of three layouts. The first maps one flat 8 KB bank. The second sends the access to an on-cart 8 KB pattern RAM. The third places the inner 1 KB banks inside an outer window. The third layout can also take four 1 KB slots from separate bank sources.

The mapping is computed in one combinational stage. The physical address and the RAM select are then registered, so every result appears one clock after its inputs. The inner mapper's own bank registers and all register write paths lie outside this block. They arrive here as plain inputs.

Top module: `chr_bank_mapper`

## Requirements
- R1: While `rst` is high at a rising edge, `chr_addr_o` and `ram_sel_o` are cleared to zero on that edge.
- R2: When bit 6 of `ext_mode_i` is 1, the 8-bit bank number is `ext_outer_i` ORed with the zero-extended `latch_i`. The output is that bank number followed by `addr_i[12:0]`, and `ram_sel_o` is 0.
- R3: Bit 6 of `ext_mode_i` takes priority over bit 5. When both bits are 1, the flat 8 KB layout of R2 applies.
- R4: When bit 6 is 0 and bit 5 is 1, `ram_sel_o` is 1. The output is `{8'b0, inner_bank_i[2:0], addr_i[9:0]}`, so a RAM access wraps within 8 KB.
- R5: When bits 6 and 5 are both 0, the 1 KB bank is the outer base ORed with the selected 1 KB bank number. The outer base is `ext_outer_i[6:0]` shifted left by 3. The output is that 11-bit bank followed by `addr_i[9:0]`, and `ram_sel_o` is 0.
- R6: In the R5 layout with bit 1 of `ext_split_i` set, slots 0..3 of the active half take their bank numbers from other sources. Slot 0 uses `base0_i`, slot 1 uses `ext_slot1_i`, slot 2 uses `base1_i` and slot 3 uses `ext_slot3_i`. The slot is `addr_i[11:10]`. In the other half, `inner_bank_i` is used.
- R7: The active half of R6 is `addr_i[12] == 0` when `cmd_i[7]` is 0, and `addr_i[12] == 1` when `cmd_i[7]` is 1.
- R8: Bit 1 of `ext_split_i`, together with `base0_i`, `base1_i`, `ext_slot1_i` and `ext_slot3_i`, has no effect on the outputs in the R2 and R4 layouts.
- R9: The outputs reflect the inputs sampled at the previous rising edge and hold steady between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 13 | Pattern-bus address inside the 8 KB window |
| inner_bank_i | input | 8 | Inner mapper's 1 KB bank for this address |
| cmd_i | input | 8 | Inner mapper command register (bit 7 swaps halves) |
| ext_mode_i | input | 8 | Layout register (bit 6 flat 8 KB, bit 5 RAM) |
| ext_outer_i | input | 8 | Outer bank / 8 KB bank register |
| ext_split_i | input | 8 | Bit 1 enables the slot override |
| ext_slot1_i | input | 8 | Bank for override slot 1 |
| ext_slot3_i | input | 8 | Bank for override slot 3 |
| latch_i | input | 2 | Latched low bits for the flat 8 KB bank |
| base0_i | input | 8 | Bank for override slot 0 |
| base1_i | input | 8 | Bank for override slot 2 |
| chr_addr_o | output | 21 | Physical pattern address |
| ram_sel_o | output | 1 | 1 selects pattern RAM, 0 selects ROM |

## Verification
The assertions assume that every input is a stable binary value at each rising edge. They also assume that a result is compared against the inputs of the edge before it. Assertions that look one cycle back are gated until a clock has passed outside reset. The bench changes inputs only on falling edges, so each check compares the registered result against the vector applied one edge earlier. Vectors that are meant to show an input has no effect set that input to values that would change the address if it were wrongly honoured.

// File: rtl/chrmap_pkg.sv
package chrmap_pkg;
  typedef enum logic [1:0] {
    LAYOUT_FLAT8K = 2'd0,
    LAYOUT_RAM    = 2'd1,
    LAYOUT_OUTER  = 2'd2
  } layout_e;

  localparam int FLAT_BIT = 6;
  localparam int RAM_BIT  = 5;
  localparam int SPLIT_BIT = 1;
endpackage

// File: rtl/chr_layout_decode.sv
module chr_layout_decode
  import chrmap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] mode_reg,
  output layout_e           layout
);
  always_comb begin
    if (mode_reg[FLAT_BIT])      layout = LAYOUT_FLAT8K;
    else if (mode_reg[RAM_BIT])  layout = LAYOUT_RAM;
    else                         layout = LAYOUT_OUTER;
  end
endmodule

// File: rtl/chr_slot_override.sv
module chr_slot_override
  import chrmap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CHR_AW = 13,
  parameter int SLOT_AW = 10
) (
  input  logic [CHR_AW-1:0] addr,
  input  logic [DATA_W-1:0] inner_bank,
  input  logic [DATA_W-1:0] cmd,
  input  logic [DATA_W-1:0] split_reg,
  input  logic [DATA_W-1:0] src0,
  input  logic [DATA_W-1:0] src1,
  input  logic [DATA_W-1:0] src2,
  input  logic [DATA_W-1:0] src3,
  output logic [DATA_W-1:0] bank_sel
);
  localparam int IDX_W = CHR_AW - SLOT_AW - 1;
  localparam int NSRC  = 1 << IDX_W;

  logic [DATA_W-1:0] srcs [NSRC];
  logic              in_half;
  logic [IDX_W-1:0]  idx;

  assign srcs[0] = src0;
  assign srcs[1] = src1;
  assign srcs[2] = src2;
  assign srcs[3] = src3;

  assign in_half = (addr[CHR_AW-1] == cmd[DATA_W-1]);
  assign idx     = addr[CHR_AW-2:SLOT_AW];

  always_comb begin
    if (split_reg[SPLIT_BIT] && in_half) bank_sel = srcs[idx];
    else                                 bank_sel = inner_bank;
  end
endmodule

// File: rtl/chr_addr_compose.sv
module chr_addr_compose
  import chrmap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CHR_AW = 13,
  parameter int SLOT_AW = 10,
  parameter int LATCH_W = 2,
  parameter int RAM_AW = 13
) (
  input  layout_e            layout,
  input  logic [CHR_AW-1:0]  addr,
  input  logic [DATA_W-1:0]  outer_reg,
  input  logic [LATCH_W-1:0] latch,
  input  logic [DATA_W-1:0]  inner_bank,
  input  logic [DATA_W-1:0]  sel_bank,
  output logic [DATA_W+CHR_AW-1:0] phys_addr,
  output logic               ram_sel
);
  localparam int SEL_W  = CHR_AW - SLOT_AW;
  localparam int BANK_W = DATA_W + SEL_W;
  localparam int OUT_AW = BANK_W + SLOT_AW;
  localparam int RAM_BW = RAM_AW - SLOT_AW;

  logic [DATA_W-1:0] flat_bank;
  logic [BANK_W-1:0] outer_base;
  logic [BANK_W-1:0] outer_bank;

  assign flat_bank  = outer_reg | {{(DATA_W-LATCH_W){1'b0}}, latch};
  assign outer_base = {1'b0, outer_reg[DATA_W-2:0], {SEL_W{1'b0}}};
  assign outer_bank = outer_base | {{SEL_W{1'b0}}, sel_bank};

  always_comb begin
    ram_sel = 1'b0;
    unique case (layout)
      LAYOUT_FLAT8K: phys_addr = {flat_bank, addr};
      LAYOUT_RAM: begin
        ram_sel   = 1'b1;
        phys_addr = {{(OUT_AW-RAM_AW){1'b0}}, inner_bank[RAM_BW-1:0], addr[SLOT_AW-1:0]};
      end
      default: phys_addr = {outer_bank, addr[SLOT_AW-1:0]};
    endcase
  end
endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper
  import chrmap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CHR_AW = 13,
  parameter int SLOT_AW = 10,
  parameter int LATCH_W = 2,
  parameter int RAM_AW = 13,
  localparam int OUT_AW = DATA_W + CHR_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CHR_AW-1:0]  addr_i,
  input  logic [DATA_W-1:0]  inner_bank_i,
  input  logic [DATA_W-1:0]  cmd_i,
  input  logic [DATA_W-1:0]  ext_mode_i,
  input  logic [DATA_W-1:0]  ext_outer_i,
  input  logic [DATA_W-1:0]  ext_split_i,
  input  logic [DATA_W-1:0]  ext_slot1_i,
  input  logic [DATA_W-1:0]  ext_slot3_i,
  input  logic [LATCH_W-1:0] latch_i,
  input  logic [DATA_W-1:0]  base0_i,
  input  logic [DATA_W-1:0]  base1_i,
  output logic [OUT_AW-1:0]  chr_addr_o,
  output logic               ram_sel_o
);
  layout_e           layout;
  logic [DATA_W-1:0] sel_bank;
  logic [OUT_AW-1:0] next_addr;
  logic              next_ram;
  logic              warm;

  chr_layout_decode #(.DATA_W(DATA_W)) u_decode (
    .mode_reg (ext_mode_i),
    .layout   (layout)
  );

  chr_slot_override #(.DATA_W(DATA_W), .CHR_AW(CHR_AW), .SLOT_AW(SLOT_AW)) u_override (
    .addr       (addr_i),
    .inner_bank (inner_bank_i),
    .cmd        (cmd_i),
    .split_reg  (ext_split_i),
    .src0       (base0_i),
    .src1       (ext_slot1_i),
    .src2       (base1_i),
    .src3       (ext_slot3_i),
    .bank_sel   (sel_bank)
  );

  chr_addr_compose #(.DATA_W(DATA_W), .CHR_AW(CHR_AW), .SLOT_AW(SLOT_AW),
                     .LATCH_W(LATCH_W), .RAM_AW(RAM_AW)) u_compose (
    .layout     (layout),
    .addr       (addr_i),
    .outer_reg  (ext_outer_i),
    .latch      (latch_i),
    .inner_bank (inner_bank_i),
    .sel_bank   (sel_bank),
    .phys_addr  (next_addr),
    .ram_sel    (next_ram)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      chr_addr_o <= '0;
      ram_sel_o  <= 1'b0;
      warm       <= 1'b0;
    end else begin
      chr_addr_o <= next_addr;
      ram_sel_o  <= next_ram;
      warm       <= 1'b1;
    end
  end

  AST_RAM_WRAP: assert property (@(posedge clk) disable iff (rst)
    ram_sel_o |-> (chr_addr_o[OUT_AW-1:RAM_AW] == '0)); // R4

  AST_RAM_LAYOUT: assert property (@(posedge clk) disable iff (rst)
    warm |-> (ram_sel_o == ($past(ext_mode_i[RAM_BIT]) && !$past(ext_mode_i[FLAT_BIT])))); // R3

  AST_FLAT_LOW: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(ext_mode_i[FLAT_BIT])) |-> (chr_addr_o[CHR_AW-1:0] == $past(addr_i))); // R2

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
    warm |-> (chr_addr_o[SLOT_AW-1:0] == $past(addr_i[SLOT_AW-1:0]))); // R9
endmodule

// File: tb/chr_bank_mapper_tb.sv
module chr_bank_mapper_tb;
  typedef struct packed {
    logic [7:0]  mode;
    logic [7:0]  outer;
    logic [7:0]  split;
    logic [7:0]  s1;
    logic [7:0]  s3;
    logic [7:0]  cmd;
    logic [7:0]  b0;
    logic [7:0]  b1;
    logic [7:0]  inner;
    logic [1:0]  latch;
    logic [12:0] addr;
    logic [20:0] exp_addr;
    logic        exp_ram;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{8'h40, 8'h12, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h33, 2'd1, 13'h1234, 21'h027234, 1'b0}, // R2
    '{8'h40, 8'hFC, 8'h02, 8'h55, 8'h66, 8'h80, 8'h77, 8'h88, 8'h01, 2'd3, 13'h0ABC, 21'h1FEABC, 1'b0}, // R2 R8
    '{8'h60, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 2'd2, 13'h1FFF, 21'h007FFF, 1'b0}, // R3
    '{8'h20, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFD, 2'd3, 13'h03FF, 21'h0017FF, 1'b1}, // R4
    '{8'h20, 8'h10, 8'h02, 8'h11, 8'h22, 8'h00, 8'h33, 8'h44, 8'h0A, 2'd0, 13'h0005, 21'h000805, 1'b1}, // R4 R8
    '{8'h00, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 2'd3, 13'h1C21, 21'h00AC21, 1'b0}, // R5
    '{8'h00, 8'h85, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hF0, 2'd0, 13'h0000, 21'h03E000, 1'b0}, // R5
    '{8'h00, 8'h01, 8'h02, 8'h21, 8'h23, 8'h00, 8'h20, 8'h22, 8'h07, 2'd0, 13'h0011, 21'h00A011, 1'b0}, // R6 slot0
    '{8'h00, 8'h01, 8'h02, 8'h21, 8'h23, 8'h00, 8'h20, 8'h22, 8'h07, 2'd0, 13'h0411, 21'h00A411, 1'b0}, // R6 slot1
    '{8'h00, 8'h01, 8'h02, 8'h21, 8'h23, 8'h00, 8'h20, 8'h22, 8'h07, 2'd0, 13'h0811, 21'h00A811, 1'b0}, // R6 slot2
    '{8'h00, 8'h01, 8'h02, 8'h21, 8'h23, 8'h00, 8'h20, 8'h22, 8'h07, 2'd0, 13'h0C11, 21'h00AC11, 1'b0}, // R6 slot3
    '{8'h00, 8'h01, 8'h02, 8'h21, 8'h23, 8'h00, 8'h20, 8'h22, 8'h07, 2'd0, 13'h1011, 21'h003C11, 1'b0}, // R6 other half
    '{8'h00, 8'h01, 8'h02, 8'h21, 8'h23, 8'h80, 8'h20, 8'h22, 8'h07, 2'd0, 13'h1811, 21'h00A811, 1'b0}, // R7 swapped slot2
    '{8'h00, 8'h01, 8'h02, 8'h21, 8'h23, 8'h80, 8'h20, 8'h22, 8'h07, 2'd0, 13'h0411, 21'h003C11, 1'b0}  // R7 low half inner
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [12:0] addr_i;
  logic [7:0]  inner_bank_i, cmd_i, ext_mode_i, ext_outer_i, ext_split_i;
  logic [7:0]  ext_slot1_i, ext_slot3_i, base0_i, base1_i;
  logic [1:0]  latch_i;
  logic [20:0] chr_addr_o;
  logic        ram_sel_o;
  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  chr_bank_mapper u_dut (
    .clk(clk), .rst(rst), .addr_i(addr_i), .inner_bank_i(inner_bank_i),
    .cmd_i(cmd_i), .ext_mode_i(ext_mode_i), .ext_outer_i(ext_outer_i),
    .ext_split_i(ext_split_i), .ext_slot1_i(ext_slot1_i), .ext_slot3_i(ext_slot3_i),
    .latch_i(latch_i), .base0_i(base0_i), .base1_i(base1_i),
    .chr_addr_o(chr_addr_o), .ram_sel_o(ram_sel_o)
  );

  task automatic apply(input vec_t v);
    ext_mode_i = v.mode;  ext_outer_i = v.outer; ext_split_i = v.split;
    ext_slot1_i = v.s1;   ext_slot3_i = v.s3;    cmd_i = v.cmd;
    base0_i = v.b0;       base1_i = v.b1;        inner_bank_i = v.inner;
    latch_i = v.latch;    addr_i = v.addr;
  endtask

  task automatic check(input string req, input logic [20:0] ea, input logic er);
    total++;
    if (chr_addr_o !== ea || ram_sel_o !== er) begin
      bad++;
      $display("FAIL %s: addr=%h ram=%b expected addr=%h ram=%b", req, chr_addr_o, ram_sel_o, ea, er);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    apply(TBL[0]);
    repeat (3) @(negedge clk);
    check("R1 reset", 21'h0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(TBL[i]);
      @(negedge clk);
      check($sformatf("vector %0d", i), TBL[i].exp_addr, TBL[i].exp_ram);
    end

    // R9: a new vector does not show before the next rising edge
    @(negedge clk);
    apply(TBL[3]);
    @(negedge clk);
    apply(TBL[0]);
    #2;
    check("R9 hold", TBL[3].exp_addr, TBL[3].exp_ram);
    @(negedge clk);
    check("R9 update", TBL[0].exp_addr, TBL[0].exp_ram);

    // R1: reset while mapping a RAM access
    apply(TBL[4]);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", 21'h0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R4 after reset", TBL[4].exp_addr, TBL[4].exp_ram);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule